// File: doc/BRIEF.md
# Key Event Flags and Interrupt

This block turns a stream of committed key state vectors into sticky per-key event flags. Each time the scanner presents a new committed vector with an update strobe, the block compares it with the vector it last accepted. A key whose state drops from 1 (released) to 0 (pressed) raises its press flag. A key whose state rises from 0 to 1 raises its release flag. A separate sticky flag records a three-key-reset event.

Software clears the per-key flags and the three-key-reset flag with write-one-to-clear strobes. Two summary outputs report whether any press flag or any release flag is still up. A combined key flag and one interrupt line are formed from the summaries, the three-key-reset flag and three enable inputs.

The summaries are not stored bits. They stay asserted until every per-key flag in their group has been cleared, which can take one clear per bit. The scanner and the bus decoding sit outside this block.

Top module: `key_event_irq`

## Requirements
- R1: After reset every press flag, release flag, summary, the three-key-reset flag, the key flag and the interrupt are 0. The stored previous vector is all ones, so a first update with all ones raises no flag.
- R2: On a cycle with the update strobe high, every key whose stored previous state is 1 and whose new state is 0 has its press flag at 1 from the next cycle on.
- R3: On a cycle with the update strobe high, every key whose stored previous state is 0 and whose new state is 1 has its release flag at 1 from the next cycle on.
- R4: While the update strobe is low the state input is ignored. No flag is set and the stored previous vector keeps its value.
- R5: A 1 on bit k of a clear strobe clears flag k of that group on the next cycle. A 0 leaves the flag as it is. A set flag with no clear stays set.
- R6: When a per-key set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: The press summary is 1 exactly while at least one press flag is 1. It stays 1 until the last press flag is cleared.
- R8: The release summary is 1 exactly while at least one release flag is 1.
- R9: A three-key-reset event pulse sets the three-key-reset flag on the next cycle. A clear strobe clears it on the next cycle. An event together with a clear leaves it set.
- R10: The key flag is 1 exactly while the press summary, the release summary or the three-key-reset flag is 1.
- R11: The interrupt equals key_ie AND ((press_ie AND press summary) OR (rel_ie AND release summary) OR three-key-reset flag). With the default options it follows the enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_state_i | input | NUM_KEYS | Committed key state, 0 = pressed, 1 = released |
| key_upd_i | input | 1 | Strobe: key_state_i holds a new committed vector |
| tkr_evt_i | input | 1 | Three-key-reset event pulse |
| press_clr_i | input | NUM_KEYS | Write-one-to-clear strobe for the press flags |
| rel_clr_i | input | NUM_KEYS | Write-one-to-clear strobe for the release flags |
| tkr_clr_i | input | 1 | Write-one-to-clear strobe for the three-key-reset flag |
| press_ie_i | input | 1 | Press interrupt enable |
| rel_ie_i | input | 1 | Release interrupt enable |
| key_ie_i | input | 1 | Master key interrupt enable |
| press_flags_o | output | NUM_KEYS | Per-key press flags |
| rel_flags_o | output | NUM_KEYS | Per-key release flags |
| press_any_o | output | 1 | Press summary |
| rel_any_o | output | 1 | Release summary |
| tkr_flag_o | output | 1 | Three-key-reset flag |
| key_flag_o | output | 1 | Combined key flag |
| irq_o | output | 1 | Interrupt line |

## Verification
Two situations are hard to reach from the ports. The first is a hardware set meeting a software clear on the same bit in the same cycle. The bench brings it about by holding a clear strobe high on a key while the same cycle carries an update in which that key falls. It does the same for the three-key-reset event and its clear. The second is a summary that must stay up while its group is partly cleared. The bench sets flags on both edge keys and on a middle key, then clears them one bit per cycle and checks the summary, the key flag and the interrupt after every single clear.

// File: rtl/key_evt_pkg.sv
package key_evt_pkg;

   localparam int KEY_LIMIT = 256;

   typedef struct packed {
      logic press;
      logic rel;
      logic tkr;
   } evt_src_t;

   function automatic logic gate_irq(input evt_src_t src,
                                     input logic press_en,
                                     input logic rel_en,
                                     input logic master_en);
      return master_en & ((press_en & src.press) | (rel_en & src.rel) | src.tkr);
   endfunction

endpackage

// File: rtl/key_edge_flags.sv
module key_edge_flags #(
   parameter int KEYS = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [KEYS-1:0] state_i,
   input  logic            upd_i,
   input  logic [KEYS-1:0] press_clr_i,
   input  logic [KEYS-1:0] rel_clr_i,
   output logic [KEYS-1:0] press_o,
   output logic [KEYS-1:0] rel_o
);

   logic [KEYS-1:0] prev_q;
   logic [KEYS-1:0] fall;
   logic [KEYS-1:0] rise;

   // stored vector starts as "all released"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= '1;
      else if (upd_i)
         prev_q <= state_i;
   end

   for (genvar k = 0; k < KEYS; k++) begin : g_key
      logic p_q;
      logic r_q;

      assign fall[k] = upd_i & prev_q[k] & ~state_i[k];
      assign rise[k] = upd_i & ~prev_q[k] & state_i[k];

      // set has priority over a same-cycle clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            p_q <= 1'b0;
         else if (fall[k])
            p_q <= 1'b1;
         else if (press_clr_i[k])
            p_q <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= 1'b0;
         else if (rise[k])
            r_q <= 1'b1;
         else if (rel_clr_i[k])
            r_q <= 1'b0;
      end

      assign press_o[k] = p_q;
      assign rel_o[k]   = r_q;

      assert_press_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_i && prev_q[k] && !state_i[k]) |=> press_o[k]);

      assert_rel_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_i && !prev_q[k] && state_i[k]) |=> rel_o[k]);

      assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!upd_i && !press_o[k] && !rel_o[k]) |=> (!press_o[k] && !rel_o[k]));

      assert_prev_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !upd_i |=> $stable(prev_q[k]));

      assert_press_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (press_o[k] && press_clr_i[k] && !fall[k]) |=> !press_o[k]);

      assert_press_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (press_o[k] && !press_clr_i[k]) |=> press_o[k]);

      assert_rel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (rel_o[k] && !rel_clr_i[k]) |=> rel_o[k]);

      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (fall[k] && press_clr_i[k]) |=> press_o[k]);
   end

endmodule

// File: rtl/key_tkr_flag.sv
module key_tkr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (evt_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_tkr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);

   assert_tkr_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !flag_o);

   assert_tkr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && flag_o) |=> flag_o);

endmodule

// File: rtl/key_irq_combine.sv
module key_irq_combine
   import key_evt_pkg::*;
#(
   parameter int KEYS    = 48,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [KEYS-1:0] press_i,
   input  logic [KEYS-1:0] rel_i,
   input  logic            tkr_i,
   input  logic            press_ie_i,
   input  logic            rel_ie_i,
   input  logic            key_ie_i,
   output logic            press_any_o,
   output logic            rel_any_o,
   output logic            key_flag_o,
   output logic            irq_o
);

   evt_src_t src;
   logic     irq_raw;

   // summaries are plain reductions: they fall only when the group is empty
   assign src.press = |press_i;
   assign src.rel   = |rel_i;
   assign src.tkr   = tkr_i;

   assign press_any_o = src.press;
   assign rel_any_o   = src.rel;
   assign key_flag_o  = src.press | src.rel | src.tkr;
   assign irq_raw     = gate_irq(src, press_ie_i, rel_ie_i, key_ie_i);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= irq_raw;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_raw;

      assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !key_ie_i |-> !irq_o);

      assert_irq_tkr_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (key_ie_i && tkr_i) |-> irq_o);
   end

   assert_press_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
      press_any_o == ($countones(press_i) != 0));

   assert_rel_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_any_o == ($countones(rel_i) != 0));

   assert_key_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tkr_i || press_any_o || rel_any_o) |-> key_flag_o);

endmodule

// File: rtl/key_event_irq.sv
module key_event_irq
   import key_evt_pkg::*;
#(
   parameter int NUM_KEYS = 48,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] key_state_i,
   input  logic                key_upd_i,
   input  logic                tkr_evt_i,
   input  logic [NUM_KEYS-1:0] press_clr_i,
   input  logic [NUM_KEYS-1:0] rel_clr_i,
   input  logic                tkr_clr_i,
   input  logic                press_ie_i,
   input  logic                rel_ie_i,
   input  logic                key_ie_i,
   output logic [NUM_KEYS-1:0] press_flags_o,
   output logic [NUM_KEYS-1:0] rel_flags_o,
   output logic                press_any_o,
   output logic                rel_any_o,
   output logic                tkr_flag_o,
   output logic                key_flag_o,
   output logic                irq_o
);

   if (NUM_KEYS < 1 || NUM_KEYS > KEY_LIMIT) begin : g_bad_keys
      $error("key_event_irq: NUM_KEYS out of range");
   end

   logic tkr_flag;

   key_edge_flags #(.KEYS(NUM_KEYS)) i_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (key_state_i),
      .upd_i       (key_upd_i),
      .press_clr_i (press_clr_i),
      .rel_clr_i   (rel_clr_i),
      .press_o     (press_flags_o),
      .rel_o       (rel_flags_o)
   );

   key_tkr_flag i_tkr (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (tkr_evt_i),
      .clr_i  (tkr_clr_i),
      .flag_o (tkr_flag)
   );

   key_irq_combine #(.KEYS(NUM_KEYS), .IRQ_REG(IRQ_REG)) i_comb (
      .clk         (clk),
      .rst_n       (rst_n),
      .press_i     (press_flags_o),
      .rel_i       (rel_flags_o),
      .tkr_i       (tkr_flag),
      .press_ie_i  (press_ie_i),
      .rel_ie_i    (rel_ie_i),
      .key_ie_i    (key_ie_i),
      .press_any_o (press_any_o),
      .rel_any_o   (rel_any_o),
      .key_flag_o  (key_flag_o),
      .irq_o       (irq_o)
   );

   assign tkr_flag_o = tkr_flag;

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (press_flags_o == '0 && rel_flags_o == '0 && !tkr_flag_o));

endmodule

// File: tb/test_key_event_irq.sv
module test_key_event_irq;

   localparam int NK = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NK-1:0] key_state = '1;
   logic          key_upd = 1'b0;
   logic          tkr_evt = 1'b0;
   logic [NK-1:0] press_clr = '0;
   logic [NK-1:0] rel_clr = '0;
   logic          tkr_clr = 1'b0;
   logic          press_ie = 1'b0;
   logic          rel_ie = 1'b0;
   logic          key_ie = 1'b0;
   logic [NK-1:0] press_flags;
   logic [NK-1:0] rel_flags;
   logic          press_any, rel_any, tkr_flag, key_flag, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model state
   logic [NK-1:0] m_prev = '1;
   logic [NK-1:0] m_press = '0;
   logic [NK-1:0] m_rel = '0;
   logic          m_tkr = 1'b0;

   always #2 clk = ~clk;

   key_event_irq #(.NUM_KEYS(NK)) i_key_event_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .key_state_i   (key_state),
      .key_upd_i     (key_upd),
      .tkr_evt_i     (tkr_evt),
      .press_clr_i   (press_clr),
      .rel_clr_i     (rel_clr),
      .tkr_clr_i     (tkr_clr),
      .press_ie_i    (press_ie),
      .rel_ie_i      (rel_ie),
      .key_ie_i      (key_ie),
      .press_flags_o (press_flags),
      .rel_flags_o   (rel_flags),
      .press_any_o   (press_any),
      .rel_any_o     (rel_any),
      .tkr_flag_o    (tkr_flag),
      .key_flag_o    (key_flag),
      .irq_o         (irq)
   );

   task automatic cmp(input string tag, input string what,
                      input logic [NK-1:0] act, input logic [NK-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      logic e_kf, e_irq;
      e_kf  = (|m_press) | (|m_rel) | m_tkr;
      e_irq = key_ie & ((press_ie & (|m_press)) | (rel_ie & (|m_rel)) | m_tkr);
      cmp(tag, "press_flags", press_flags, m_press);
      cmp(tag, "rel_flags", rel_flags, m_rel);
      cmp(tag, "press_any", NK'(press_any), NK'(|m_press));
      cmp(tag, "rel_any", NK'(rel_any), NK'(|m_rel));
      cmp(tag, "tkr_flag", NK'(tkr_flag), NK'(m_tkr));
      cmp(tag, "key_flag", NK'(key_flag), NK'(e_kf));
      cmp(tag, "irq", NK'(irq), NK'(e_irq));
   endtask

   // one clock: drive, take the edge, update the model, check
   task automatic cyc(input logic [NK-1:0] st, input logic v,
                      input logic [NK-1:0] pc, input logic [NK-1:0] rc,
                      input logic te, input logic tc, input string tag);
      logic [NK-1:0] sp, sr;
      key_state = st; key_upd = v; press_clr = pc; rel_clr = rc;
      tkr_evt = te; tkr_clr = tc;
      @(posedge clk);
      sp = v ? (m_prev & ~st) : '0;
      sr = v ? (~m_prev & st) : '0;
      m_press = (m_press & ~pc) | sp;
      m_rel   = (m_rel & ~rc) | sr;
      if (v) m_prev = st;
      m_tkr = (m_tkr & ~tc) | te;
      #1;
      key_upd = 1'b0; press_clr = '0; rel_clr = '0; tkr_evt = 1'b0; tkr_clr = 1'b0;
      chk_all(tag);
   endtask

   task automatic upd(input logic [NK-1:0] st, input string tag);
      cyc(st, 1'b1, '0, '0, 1'b0, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      cyc(key_state, 1'b0, '0, '0, 1'b0, 1'b0, tag);
   endtask

   task automatic t_reset;
      chk_all("R1 reset");
      upd('1, "R1 first all-ones update");
   endtask

   task automatic t_press;
      logic [NK-1:0] st;
      st = '1; st[0] = 1'b0; st[NK-1] = 1'b0;
      upd(st, "R2 press edges");
      upd(st, "R2 repeat same vector");
   endtask

   task automatic t_release;
      upd('1, "R3 release edges");
      idle("R5 flags hold");
   endtask

   task automatic t_no_strobe;
      cyc(48'h0, 1'b0, '0, '0, 1'b0, 1'b0, "R4 state ignored without strobe");
      upd('1, "R4 previous vector kept");
   endtask

   task automatic t_w1c;
      cyc('1, 1'b0, '0, '0, 1'b0, 1'b0, "R5 zero clear no effect");
      cyc('1, 1'b0, 48'h1, 48'h0, 1'b0, 1'b0, "R5 clear press bit0");
      cyc('1, 1'b0, {1'b1, 47'h0}, 48'h1, 1'b0, 1'b0, "R5 clear press top and rel bit0");
      cyc('1, 1'b0, '0, '1, 1'b0, 1'b0, "R5 clear all release");
   endtask

   task automatic t_summary;
      logic [NK-1:0] st;
      st = '1; st[0] = 1'b0; st[20] = 1'b0; st[NK-1] = 1'b0;
      press_ie = 1'b1; key_ie = 1'b1;
      upd(st, "R7 set three presses");
      cyc(st, 1'b0, 48'h1, '0, 1'b0, 1'b0, "R7 summary holds after first clear");
      cyc(st, 1'b0, 48'h1 << 20, '0, 1'b0, 1'b0, "R7 summary holds after second clear");
      cyc(st, 1'b0, 48'h1 << (NK-1), '0, 1'b0, 1'b0, "R7 summary falls after last clear");
      rel_ie = 1'b1;
      upd('1, "R8 three releases");
      cyc('1, 1'b0, '0, 48'h1 << 20, 1'b0, 1'b0, "R8 summary holds");
      cyc('1, 1'b0, '0, 48'h1 | (48'h1 << (NK-1)), 1'b0, 1'b0, "R8 summary falls");
   endtask

   task automatic t_set_wins;
      logic [NK-1:0] st;
      st = '1; st[5] = 1'b0;
      cyc(st, 1'b1, 48'h1 << 5, '0, 1'b0, 1'b0, "R6 set beats clear on same bit");
      cyc('1, 1'b1, 48'h1 << 5, 48'h1 << 5, 1'b0, 1'b0, "R6 release set beats clear, press cleared");
      cyc('1, 1'b0, '0, 48'h1 << 5, 1'b0, 1'b0, "R5 release bit5 cleared");
   endtask

   task automatic t_tkr;
      press_ie = 1'b0; rel_ie = 1'b0; key_ie = 1'b1;
      cyc('1, 1'b0, '0, '0, 1'b1, 1'b0, "R9 tkr event sets, R10 key flag");
      idle("R9 tkr holds");
      cyc('1, 1'b0, '0, '0, 1'b0, 1'b1, "R9 tkr cleared");
      cyc('1, 1'b0, '0, '0, 1'b1, 1'b1, "R9 tkr event beats clear");
      cyc('1, 1'b0, '0, '0, 1'b0, 1'b1, "R9 tkr cleared again");
   endtask

   task automatic t_irq;
      logic [NK-1:0] st;
      st = '1; st[9] = 1'b0;
      press_ie = 1'b0; rel_ie = 1'b0; key_ie = 1'b1;
      upd(st, "R11 press flag with press_ie low");
      press_ie = 1'b1; #1; chk_all("R11 press_ie high");
      key_ie = 1'b0; #1; chk_all("R11 master low masks");
      key_ie = 1'b1;
      cyc(st, 1'b0, 48'h1 << 9, '0, 1'b0, 1'b0, "R11 cleared press drops irq");
      upd('1, "R11 release with rel_ie low");
      rel_ie = 1'b1; #1; chk_all("R11 rel_ie high");
      press_ie = 1'b0; #1; chk_all("R11 rel path alone");
      cyc('1, 1'b0, '0, '1, 1'b1, 1'b0, "R11 tkr drives irq without sub-enables");
      rel_ie = 1'b0; #1; chk_all("R11 tkr path");
      key_ie = 1'b0; #1; chk_all("R11 tkr masked by master");
   endtask

   task automatic t_pattern;
      key_ie = 1'b1; press_ie = 1'b1; rel_ie = 1'b1;
      cyc('1, 1'b0, '0, '0, 1'b0, 1'b1, "R10 clean start");
      upd(48'hAAAA_5555_F0F0, "R2 mixed press pattern");
      upd(48'h5555_AAAA_0F0F, "R3 mixed swap pattern");
      cyc(48'h5555_AAAA_0F0F, 1'b0, '1, '1, 1'b0, 1'b0, "R5 clear everything");
      upd(48'h0, "R2 all pressed");
      upd('1, "R3 all released");
   endtask

   initial begin
      #1;
      chk_all("R1 in reset");
      #10 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_press();
      t_release();
      t_no_strobe();
      t_w1c();
      t_summary();
      t_set_wins();
      t_tkr();
      t_irq();
      t_pattern();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule